// File: doc/BRIEF.md
# Bit-Plane Weighted Output-Enable Modulator

This block drives the shared, active-high output-enable line of a multiplexed LED matrix. Grey levels come from showing one bit plane of the image per sub-frame. Within each sub-frame the enable pulse for every row lasts a time proportional to the binary weight of that plane. A full grey-level frame therefore takes as many sub-frames as the image has bits of shading, and it needs no per-pixel duty value.

A scan controller pulses a start input when a row has been latched and presents the plane index it is showing. The block stores the pulse length that belongs to that index in an active compare counter, raises the enable and lowers it after the weighted time. It flags the fall with a one-cycle done pulse. A force-off input zeroes the active compare value and drops the enable in the same cycle, so the latch line can toggle with no ghosting. A separate one-cycle flag marks the start of a new grey-level frame, which is when the plane index wraps from the top plane back to zero.

Top module: `oeplane_mod`

## Requirements
- R1: After reset, `oe`, `pulse_done` and `frame_done` are all low.
- R2: A start accepted with plane index k drives `oe` high from the cycle after the start edge for exactly (2^k)·UNIT_CYC consecutive cycles.
- R3: Index 0 (least significant plane) gives UNIT_CYC cycles, and index PLANES-1 (most significant plane) gives 2^(PLANES-1)·UNIT_CYC cycles.
- R4: While `force_off` is high, `oe` is low in that same cycle. The active compare value is cleared, so the cut pulse never resumes after `force_off` drops.
- R5: `pulse_done` is high for exactly one cycle per pulse. After a natural end it is high on the first cycle `oe` is low. When a pulse is cut, it is high in the cycle where `force_off` pulls a high enable low.
- R6: A start that arrives while the enable is high is ignored, including one on the last high cycle. The running pulse keeps its length and no second pulse follows.
- R7: A start in the same cycle as `force_off` is dropped. No pulse follows and the plane is not recorded.
- R8: The plane index is sampled only when a start is accepted. Changing it during a pulse does not change that pulse's length.
- R9: `frame_done` is high for one cycle, on the first high cycle of an accepted pulse with index 0, when the previously accepted index was PLANES-1. The previous index is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start | input | 1 | One-cycle request to open the enable for the current row |
| plane_idx | input | IDX_W | Bit plane on display, 0 = least significant |
| force_off | input | 1 | Immediate kill of the enable pulse |
| oe | output | 1 | Active-high output enable to the panels |
| pulse_done | output | 1 | One-cycle flag when the enable falls |
| frame_done | output | 1 | One-cycle flag at the wrap to plane 0 |

## Verification
The enable is due high one cycle after an accepted start. It stays high for the plane weight in cycles, and `pulse_done` is due on the first low cycle after that. The `frame_done` flag is due on the first high cycle. A forced kill is due in the same cycle, because the enable and done paths from `force_off` are combinational. The bench drives inputs on the falling edge and samples there too, half a cycle after each rising edge. It checks the forced kill 1 ns after driving `force_off`, and counts high samples against the weight computed from the index.

// File: rtl/oeplane_pkg.sv
package oeplane_pkg;
  // length of the enable pulse for bit plane k, in clock cycles
  function automatic int unsigned plane_len(input int unsigned k, input int unsigned unit);
    return (32'd1 << k) * unit;
  endfunction
endpackage

// File: rtl/oeplane_weight.sv
module oeplane_weight #(
  parameter int PLANES = 8,
  parameter int UNIT_CYC = 2,
  parameter int IDX_W = 3,
  parameter int CNT_W = 9
) (
  input  logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] len,
  output logic             in_range
);
  logic [CNT_W-1:0] table_q [PLANES];

  for (genvar g = 0; g < PLANES; g++) begin : g_len
    assign table_q[g] = CNT_W'(oeplane_pkg::plane_len(g, UNIT_CYC));
  end

  always_comb begin
    in_range = (32'(idx) < PLANES);
    len      = '0;
    if (in_range) len = table_q[idx];
  end
endmodule

// File: rtl/oeplane_timer.sv
module oeplane_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             len_ok,
  input  logic [CNT_W-1:0] len,
  input  logic             force_off,
  output logic             accept,
  output logic             oe,
  output logic             pulse_done
);
  logic             oe_q;
  logic             end_q;
  logic [CNT_W-1:0] cnt;

  assign accept     = row_start & len_ok & ~oe_q & ~force_off;
  assign oe         = oe_q & ~force_off;
  assign pulse_done = end_q | (oe_q & force_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      end_q <= 1'b0;
      cnt   <= '0;
    end else if (force_off) begin
      oe_q  <= 1'b0;
      end_q <= 1'b0;
      cnt   <= '0;
    end else if (accept) begin
      oe_q  <= 1'b1;
      end_q <= 1'b0;
      cnt   <= len;
    end else if (oe_q && cnt == CNT_W'(1)) begin
      oe_q  <= 1'b0;
      end_q <= 1'b1;
      cnt   <= '0;
    end else begin
      end_q <= 1'b0;
      if (oe_q) cnt <= cnt - CNT_W'(1);
    end
  end

  p_kill_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!oe_q && cnt == '0));

  p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !force_off && cnt > CNT_W'(1)) |=> (oe_q && cnt == $past(cnt) - CNT_W'(1)));

  p_done_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_q) && !$past(force_off)) |-> end_q);

  p_live_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> cnt != '0);
endmodule

// File: rtl/oeplane_wrap.sv
module oeplane_wrap #(
  parameter int PLANES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] idx,
  output logic             frame_done
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(PLANES - 1);

  logic [IDX_W-1:0] last_q;
  logic             frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= accept && idx == '0 && last_q == TOP;
      if (accept) last_q <= idx;
    end
  end

  assign frame_done = frame_q;

  p_wrap_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |-> ($past(accept) && $past(idx) == '0));

  p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> !frame_q);
endmodule

// File: rtl/oeplane_mod.sv
module oeplane_mod #(
  parameter int PLANES   = 8,
  parameter int UNIT_CYC = 2,
  parameter int IDX_W    = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic [IDX_W-1:0] plane_idx,
  input  logic             force_off,
  output logic             oe,
  output logic             pulse_done,
  output logic             frame_done
);
  localparam int MAXLEN = int'(oeplane_pkg::plane_len(PLANES - 1, UNIT_CYC));
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  logic [CNT_W-1:0] len;
  logic             len_ok;
  logic             accept;

  oeplane_weight #(.PLANES(PLANES), .UNIT_CYC(UNIT_CYC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_weight (
    .idx(plane_idx), .len(len), .in_range(len_ok)
  );

  oeplane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .len_ok(len_ok), .len(len),
    .force_off(force_off), .accept(accept), .oe(oe), .pulse_done(pulse_done)
  );

  oeplane_wrap #(.PLANES(PLANES), .IDX_W(IDX_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .idx(plane_idx), .frame_done(frame_done)
  );

  p_kill_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> !oe);
endmodule

// File: tb/sim_oeplane_mod.sv
`timescale 1ns/1ps
module sim_oeplane_mod;
  localparam int PLANES = 8;
  localparam int UNIT   = 2;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_start = 1'b0;
  logic [IDX_W-1:0] plane_idx = '0;
  logic force_off = 1'b0;
  logic oe, pulse_done, frame_done;

  int total = 0;
  int bad = 0;
  int last_acc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  oeplane_mod #(.PLANES(PLANES), .UNIT_CYC(UNIT)) u0 (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .plane_idx(plane_idx),
    .force_off(force_off), .oe(oe), .pulse_done(pulse_done), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int k);
    return (1 << k) * UNIT;
  endfunction

  // cut: force at high sample number cut (0 = never); poke: extra start at that high sample
  task automatic do_pulse(input int idx, input int cut, input int poke);
    int w = exp_len(idx);
    int hi = 0;
    bit was_cut = 1'b0;
    bit exp_fd = (idx == 0 && last_acc == PLANES - 1);
    last_acc = idx;
    row_start = 1'b1;
    plane_idx = IDX_W'(idx);
    @(negedge clk);
    row_start = 1'b0;
    plane_idx = IDX_W'($urandom_range(0, PLANES - 1)); // R8: index moves during the pulse
    while (oe === 1'b1 && hi <= w) begin
      hi++;
      if (hi == 1) chk(frame_done == exp_fd, "R9 frame flag on first high", int'(frame_done), int'(exp_fd));
      else         chk(frame_done == 1'b0, "R9 frame flag only once", int'(frame_done), 0);
      if (hi == cut) begin
        force_off = 1'b1;
        #1;
        chk(oe == 1'b0, "R4 enable low with force", int'(oe), 0);
        chk(pulse_done == 1'b1, "R5 done on forced fall", int'(pulse_done), 1);
        @(negedge clk);
        force_off = 1'b0;
        was_cut = 1'b1;
        break;
      end
      if (hi == poke) begin
        row_start = 1'b1;
        plane_idx = IDX_W'($urandom_range(0, PLANES - 1));
      end
      @(negedge clk);
      row_start = 1'b0;
    end
    if (was_cut) begin
      chk(pulse_done == 1'b0, "R5 done single cycle after cut", int'(pulse_done), 0);
      for (int i = 0; i < 3; i++) begin
        chk(oe == 1'b0, "R4 cut pulse stays off", int'(oe), 0);
        @(negedge clk);
      end
    end else begin
      chk(hi == w, (idx == 0 || idx == PLANES - 1) ? "R3 end plane length" :
                   (poke != 0 ? "R6 length with ignored start" : "R2 pulse length"), hi, w);
      chk(pulse_done == 1'b1, "R5 done on first low cycle", int'(pulse_done), 1);
      @(negedge clk);
      chk(pulse_done == 1'b0, "R5 done single cycle", int'(pulse_done), 0);
      chk(oe == 1'b0, "R6 no pulse from ignored start", int'(oe), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(oe == 1'b0, "R1 reset enable", int'(oe), 0);
    chk(pulse_done == 1'b0, "R1 reset done", int'(pulse_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0 && pulse_done == 1'b0 && frame_done == 1'b0, "R1 idle after reset",
        int'({oe, pulse_done, frame_done}), 0);

    // directed: whole frame LSB to MSB, then the wrap
    for (int k = 0; k < PLANES; k++) do_pulse(k, 0, 0);
    do_pulse(0, 0, 0);
    // start on the last high cycle is ignored
    do_pulse(3, 0, exp_len(3));
    do_pulse(5, 0, 4);
    // forced cuts, first and mid cycle
    do_pulse(6, 1, 0);
    do_pulse(4, 7, 0);

    // start with force in the same cycle: dropped and not recorded
    do_pulse(PLANES - 1, 0, 0);
    row_start = 1'b1;
    plane_idx = '0;
    force_off = 1'b1;
    @(negedge clk);
    row_start = 1'b0;
    force_off = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(oe == 1'b0 && frame_done == 1'b0, "R7 start dropped under force", int'({oe, frame_done}), 0);
      @(negedge clk);
    end
    do_pulse(0, 0, 0); // R9: last recorded is still the top plane, so the wrap flag fires here

    // random mix
    for (int n = 0; n < 40; n++) begin
      int k = $urandom_range(0, PLANES - 1);
      int w = exp_len(k);
      int cut = ($urandom_range(0, 3) == 0) ? $urandom_range(1, w) : 0;
      int poke = ($urandom_range(0, 2) == 0) ? $urandom_range(1, w) : 0;
      do_pulse(k, cut, poke);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule